// File: doc/BRIEF.md
# Fifteen-Bit Wrapping Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small 16-bit processor whose values live in a 15-bit range. Each cycle it takes an operation code and two 16-bit operand words. It forces the top bit of each operand to zero and then computes one of eight functions:

- a sum and a product, both wrapping modulo 32768;
- a remainder;
- bitwise AND, OR and a 15-bit inverse;
- an equality compare and an unsigned greater-than compare, each giving a literal 0 or 1.

The result is captured in a register on the next rising clock edge. A separate registered flag reports a remainder request whose divisor is zero, so the surrounding core can stop with an error.

The core chooses the operation, fetches the operands and writes the result back. This unit does no sequencing of its own. It accepts a new operation on every cycle, and each result appears exactly one cycle later.

Top module: `alu15_core`

## Requirements
- R1: A synchronous active-high reset clears the result register and the divide-by-zero flag to 0 on the next rising edge, even while an operation is being presented.
- R2: The result and flag for the inputs presented before a rising edge appear right after that edge, and they do not change before it. Back-to-back operations are accepted on every cycle.
- R3: Operation code 9 gives (B + C) mod 32768.
- R4: Operation code 10 gives the low 15 bits of B × C.
- R5: Operation code 11 gives B mod C with flag 0 when C ≠ 0. When C = 0 it gives result 0 with flag 1.
- R6: Operation code 12 gives B AND C, and operation code 13 gives B OR C.
- R7: Operation code 14 gives the 15-bit inverse of B, and C has no effect on it.
- R8: Operation code 4 gives 1 when B = C and 0 otherwise. Operation code 5 gives 1 when B > C (unsigned) and 0 otherwise.
- R9: Any other operation code (0–3, 6–8, 15) gives result 0 with flag 0.
- R10: Bit 15 of each operand is ignored: every operation sees only bits 14..0 of B and C.
- R11: Bit 15 of the result is always 0. The flag is 1 only after a code-11 operation whose masked divisor is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd_b | input | 16 | First operand word (bit 15 ignored) |
| opnd_c | input | 16 | Second operand word (bit 15 ignored) |
| res_q | output | 16 | Registered result, bit 15 always 0 |
| dz_q | output | 1 | Registered divide-by-zero flag |

## Verification
The hardest case to reach is a zero divisor that only appears after masking. This happens when the divisor word is 0x8000: it is non-zero at the port but zero inside the unit. The vector table includes that word, and also operands with bit 15 set for the add, equality, AND and inverse operations, so that any leak of the top bit changes a result.

A second case is a reset that arrives while a divide-by-zero result is pending. A directed step holds a zero-divisor remainder on the inputs, raises reset at the same edge, and then checks that both outputs read zero.

// File: rtl/alu15_pkg.sv
`timescale 1ns/1ps
package alu15_pkg;
  typedef enum logic [3:0] {
    OP_EQ   = 4'd4,
    OP_GT   = 4'd5,
    OP_ADD  = 4'd9,
    OP_MUL  = 4'd10,
    OP_REM  = 4'd11,
    OP_AND  = 4'd12,
    OP_OR   = 4'd13,
    OP_INV  = 4'd14
  } alu_op_e;
endpackage

// File: rtl/alu15_arith.sv
`timescale 1ns/1ps
// Wrapping sum and product: the result width truncates to VAL_W bits.
module alu15_arith #(
  parameter int VAL_W = 15
) (
  input  logic [VAL_W-1:0] b_i,
  input  logic [VAL_W-1:0] c_i,
  output logic [VAL_W-1:0] sum_o,
  output logic [VAL_W-1:0] prod_o
);
  assign sum_o  = b_i + c_i;
  assign prod_o = b_i * c_i;
endmodule

// File: rtl/alu15_rem.sv
`timescale 1ns/1ps
// Remainder with zero-divisor detection.
module alu15_rem #(
  parameter int VAL_W = 15
) (
  input  logic [VAL_W-1:0] b_i,
  input  logic [VAL_W-1:0] c_i,
  output logic [VAL_W-1:0] rem_o,
  output logic             zero_div_o
);
  always_comb begin
    zero_div_o = (c_i == '0);
    if (zero_div_o) rem_o = '0;
    else            rem_o = b_i % c_i;
  end
endmodule

// File: rtl/alu15_logic.sv
`timescale 1ns/1ps
// Bitwise operations and compares.
module alu15_logic #(
  parameter int VAL_W = 15
) (
  input  logic [VAL_W-1:0] b_i,
  input  logic [VAL_W-1:0] c_i,
  output logic [VAL_W-1:0] and_o,
  output logic [VAL_W-1:0] or_o,
  output logic [VAL_W-1:0] inv_o,
  output logic             eq_o,
  output logic             gt_o
);
  assign and_o = b_i & c_i;
  assign or_o  = b_i | c_i;
  assign inv_o = ~b_i;
  assign eq_o  = (b_i == c_i);
  assign gt_o  = (b_i > c_i);
endmodule

// File: rtl/alu15_core.sv
`timescale 1ns/1ps
module alu15_core
  import alu15_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VAL_W  = 15,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] opnd_c,
  output logic [WORD_W-1:0] res_q,
  output logic              dz_q
);
  localparam int PAD_W = WORD_W - VAL_W;

  // Masking: only the low VAL_W bits take part in any operation.
  logic [VAL_W-1:0] b_m, c_m;
  logic             unused_hi_bits;
  assign b_m = opnd_b[VAL_W-1:0];
  assign c_m = opnd_c[VAL_W-1:0];
  assign unused_hi_bits = ^{opnd_b[WORD_W-1:VAL_W], opnd_c[WORD_W-1:VAL_W]};

  logic [VAL_W-1:0] sum_v, prod_v, rem_v, and_v, or_v, inv_v;
  logic             zdiv_v, eq_v, gt_v;

  alu15_arith #(.VAL_W(VAL_W)) u_arith (
    .b_i(b_m), .c_i(c_m), .sum_o(sum_v), .prod_o(prod_v)
  );

  alu15_rem #(.VAL_W(VAL_W)) u_rem (
    .b_i(b_m), .c_i(c_m), .rem_o(rem_v), .zero_div_o(zdiv_v)
  );

  alu15_logic #(.VAL_W(VAL_W)) u_logic (
    .b_i(b_m), .c_i(c_m), .and_o(and_v), .or_o(or_v), .inv_o(inv_v),
    .eq_o(eq_v), .gt_o(gt_v)
  );

  logic [VAL_W-1:0] val_nx;
  logic             dz_nx;

  always_comb begin
    val_nx = '0;
    dz_nx  = 1'b0;
    case (op_sel)
      OP_EQ:  val_nx = {{(VAL_W-1){1'b0}}, eq_v};
      OP_GT:  val_nx = {{(VAL_W-1){1'b0}}, gt_v};
      OP_ADD: val_nx = sum_v;
      OP_MUL: val_nx = prod_v;
      OP_REM: begin
        val_nx = rem_v;
        dz_nx  = zdiv_v;
      end
      OP_AND: val_nx = and_v;
      OP_OR:  val_nx = or_v;
      OP_INV: val_nx = inv_v;
      default: val_nx = '0;
    endcase
  end

  // Output register, synchronous reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      dz_q  <= 1'b0;
    end else begin
      res_q <= {{PAD_W{1'b0}}, val_nx};
      dz_q  <= dz_nx;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (res_q == '0 && !dz_q));

  // R11
  res_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_q[WORD_W-1:VAL_W] == '0));

  // R5
  dz_res_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dz_q |-> (res_q == '0));

  // R11
  dz_only_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel != OP_REM) |=> !dz_q);

  // R8
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_EQ || op_sel == OP_GT) |=> ($countones(res_q) <= 1 && res_q[WORD_W-1:1] == '0));

  // R9
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel < 4'd4 || (op_sel > 4'd5 && op_sel < 4'd9) || op_sel == 4'd15)
      |=> (res_q == '0 && !dz_q));

  // R10
  inv_ignores_c_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_INV && opnd_b[VAL_W-1:0] == '0) |=> (res_q == {{PAD_W{1'b0}}, {VAL_W{1'b1}}}));
endmodule

// File: tb/alu15_core_tb.sv
`timescale 1ns/1ps
module alu15_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [15:0] opnd_b = '0;
  logic [15:0] opnd_c = '0;
  logic [15:0] res_q;
  logic        dz_q;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  alu15_core u_dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_b(opnd_b),
    .opnd_c(opnd_c), .res_q(res_q), .dz_q(dz_q)
  );

  // {op, b, c, expected result, expected flag}
  localparam int NV = 31;
  localparam logic [52:0] VEC [NV] = '{
    {4'd9,  16'h0003, 16'h0004, 16'h0007, 1'b0}, // R3
    {4'd9,  16'h7FFF, 16'h0001, 16'h0000, 1'b0}, // R3 wrap
    {4'd9,  16'h7FFF, 16'h7FFF, 16'h7FFE, 1'b0}, // R3
    {4'd9,  16'h8005, 16'h0002, 16'h0007, 1'b0}, // R10
    {4'd10, 16'h0006, 16'h0007, 16'h002A, 1'b0}, // R4
    {4'd10, 16'h4000, 16'h0002, 16'h0000, 1'b0}, // R4 wrap
    {4'd10, 16'h7FFF, 16'h7FFF, 16'h0001, 1'b0}, // R4
    {4'd10, 16'd300,  16'd200,  16'h6A60, 1'b0}, // R4
    {4'd11, 16'd17,   16'd5,    16'd2,    1'b0}, // R5
    {4'd11, 16'd5,    16'd17,   16'd5,    1'b0}, // R5
    {4'd11, 16'd100,  16'd0,    16'd0,    1'b1}, // R5 zero divisor
    {4'd11, 16'hFFFF, 16'h8000, 16'd0,    1'b1}, // R10 masked zero divisor
    {4'd11, 16'h7FFF, 16'd16,   16'd15,   1'b0}, // R5
    {4'd12, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0}, // R6 R10
    {4'd13, 16'h1200, 16'h0034, 16'h1234, 1'b0}, // R6
    {4'd13, 16'h8000, 16'h8000, 16'h0000, 1'b0}, // R6 R10
    {4'd14, 16'h0000, 16'h1234, 16'h7FFF, 1'b0}, // R7
    {4'd14, 16'h7FFF, 16'h0000, 16'h0000, 1'b0}, // R7
    {4'd14, 16'h8001, 16'hFFFF, 16'h7FFE, 1'b0}, // R7 R10
    {4'd4,  16'd5,    16'd5,    16'd1,    1'b0}, // R8
    {4'd4,  16'd5,    16'd6,    16'd0,    1'b0}, // R8
    {4'd4,  16'h8005, 16'd5,    16'd1,    1'b0}, // R8 R10
    {4'd5,  16'd6,    16'd5,    16'd1,    1'b0}, // R8
    {4'd5,  16'd5,    16'd5,    16'd0,    1'b0}, // R8
    {4'd5,  16'h7FFF, 16'd0,    16'd1,    1'b0}, // R8
    {4'd5,  16'd0,    16'h7FFF, 16'd0,    1'b0}, // R8
    {4'd0,  16'd3,    16'd4,    16'd0,    1'b0}, // R9
    {4'd1,  16'd3,    16'd0,    16'd0,    1'b0}, // R9
    {4'd8,  16'd0,    16'd0,    16'd0,    1'b0}, // R9
    {4'd15, 16'h7FFF, 16'd0,    16'd0,    1'b0}, // R9
    {4'd2,  16'd9,    16'd0,    16'd0,    1'b0}  // R9
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd9:         return "R3";
      4'd10:        return "R4";
      4'd11:        return "R5";
      4'd12, 4'd13: return "R6";
      4'd14:        return "R7";
      4'd4, 4'd5:   return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", res_q, 16'h0000);
    check("R1", {15'd0, dz_q}, 16'h0000);
    rst = 1'b0;

    // R2: inputs change before an edge; output holds until the edge
    op_sel = 4'd9; opnd_b = 16'd1; opnd_c = 16'd2;
    #1 check("R2", res_q, 16'h0000);
    @(negedge clk);
    check("R2", res_q, 16'h0003);

    // Table walk, one vector per cycle
    for (int i = 0; i < NV; i++) begin
      op_sel = VEC[i][52:49];
      opnd_b = VEC[i][48:33];
      opnd_c = VEC[i][32:17];
      @(negedge clk);
      check(req_of(VEC[i][52:49]), res_q, VEC[i][16:1]);
      check(req_of(VEC[i][52:49]), {15'd0, dz_q}, {15'd0, VEC[i][0]});
      check("R11", {15'd0, res_q[15]}, 16'h0000);
    end

    // R11: flag clears when the next operation is not a remainder
    op_sel = 4'd11; opnd_b = 16'd7; opnd_c = 16'd0;
    @(negedge clk);
    check("R5", {15'd0, dz_q}, 16'h0001);
    op_sel = 4'd9; opnd_b = 16'd1; opnd_c = 16'd0;
    @(negedge clk);
    check("R11", {15'd0, dz_q}, 16'h0000);
    check("R3", res_q, 16'h0001);

    // R1: reset wins over a pending zero-divisor result
    op_sel = 4'd11; opnd_b = 16'd7; opnd_c = 16'h8000;
    rst = 1'b1;
    @(negedge clk);
    check("R1", res_q, 16'h0000);
    check("R1", {15'd0, dz_q}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R10", {15'd0, dz_q}, 16'h0001);

    finish_run();
  end
endmodule